// File: doc/BRIEF.md
# Crypto Job Descriptor Fetcher and Parcel Dispatcher

This block starts one cryptographic job at a time. A host rings a doorbell with the base address of a 64-byte job descriptor. The block then reads the descriptor through a 64-bit memory port, one word after another, starting at the base address. Word 0 is the header. The block keeps the upper half of the header, which is the control half. Words 1 to 7 are pointer slots, and they all share one layout. For each slot with a non-zero length, the block places one parcel request on a ready/valid port that goes to a downstream data mover.

Each parcel request carries the following:
- the slot number;
- a 36-bit address;
- the length;
- the extent;
- a jump flag, which marks the address as a link table for scatter or gather rather than a contiguous region;
- a direction bit, taken from a per-slot configuration mask.

After the last slot, the block waits for the downstream job-done strobe. If writeback was enabled when the job started, the block then writes a status word into the lower half of the header. A read error during the fetch aborts the job and raises an error flag.

Top module: `desc_fetch_dispatch`

## Requirements
- R1: During and right after reset, `busy`, `err`, `mem_req` and `prq_valid` are all low.
- R2: The fetch performs exactly eight single-word reads, at base + 8*k for k = 0 to 7 in ascending order. Each read is held, with a stable address, until `mem_ack`.
- R3: The pointer-word fields are taken from these bits (LSB-0 numbering):
  - length: bits [63:48];
  - jump: bit [47];
  - extent: bits [46:40];
  - address: bits [35:32] concatenated above bits [31:0];
  - bits [39:36] are ignored.
  The request slot number equals the word index, 1 to 7.
- R4: A slot whose length is zero is skipped with no request. Requests leave in ascending slot order, and every request has a non-zero length.
- R5: `prq_jump` copies the slot's jump flag. `prq_write` equals bit (slot-1) of `cfg_out_mask`, as sampled when the doorbell is accepted.
- R6: While `prq_valid` is high and `prq_ready` is low, the request stays valid and every request field stays unchanged.
- R7: Writeback happens only after `job_done`, and only if `cfg_wb_en` was high at the doorbell. It is one write to the base address, with data {header[63:32], `job_status`}. When writeback is disabled, no write occurs.
- R8: `busy` rises on the cycle after a doorbell is accepted. It falls after the writeback is acknowledged, or after `job_done` when writeback is disabled. A doorbell that arrives while `busy` is high has no effect.
- R9: If a read returns `mem_err` together with `mem_ack`, the job is aborted: no further reads or requests, no writeback, and `busy` falls with `err` set. `err` is cleared when the next doorbell is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Doorbell strobe |
| db_addr | input | AW | Descriptor base address |
| cfg_out_mask | input | NSLOT | Per-slot direction, 1 = output (bit 0 = slot 1) |
| cfg_wb_en | input | 1 | Enable status writeback |
| busy | output | 1 | Job in progress |
| err | output | 1 | Last job aborted on a read error |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Read error, valid with mem_ack |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| prq_valid | output | 1 | Parcel request valid |
| prq_ready | input | 1 | Data mover accepts request |
| prq_slot | output | SW | Slot number 1..7 |
| prq_addr | output | AW | Parcel or link-table address |
| prq_len | output | 16 | Parcel length |
| prq_ext | output | 7 | Extent |
| prq_jump | output | 1 | Address is a link table |
| prq_write | output | 1 | Slot is an output (scatter side) |
| job_done | input | 1 | Downstream job finished |
| job_status | input | 32 | Status code written back |

## Verification
The assertions check these behaviours on every cycle:
- a pending memory access or parcel request is held steady until it is taken;
- no request with zero length or slot 0 ever leaves the block;
- nothing is requested while the block is idle;
- a writeback never overlaps a parcel request;
- an error flag always means the block is idle.

Some behaviours only the bench scenarios can show:
- which slots are skipped;
- the exact field extraction and direction labelling;
- the address sequence of the eight reads;
- whether the writeback happens and what data it carries;
- that a second doorbell during a job, or a mid-fetch read error, leaves exactly the expected trail of requests.

// File: rtl/desc_fetch_dispatch.sv
module desc_fetch_dispatch #(
  parameter int NSLOT = 7,
  parameter int AW    = 36,
  parameter int SW    = $clog2(NSLOT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          db_valid,
  input  logic [AW-1:0] db_addr,
  input  logic [NSLOT-1:0] cfg_out_mask,
  input  logic          cfg_wb_en,
  output logic          busy,
  output logic          err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [63:0]   mem_rdata,
  output logic          prq_valid,
  input  logic          prq_ready,
  output logic [SW-1:0] prq_slot,
  output logic [AW-1:0] prq_addr,
  output logic [15:0]   prq_len,
  output logic [6:0]    prq_ext,
  output logic          prq_jump,
  output logic          prq_write,
  input  logic          job_done,
  input  logic [31:0]   job_status
);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_SEND, S_WAIT, S_WBACK} st_t;

  st_t           st_q;
  logic [SW-1:0] idx_q;
  logic [AW-1:0] base_q;
  logic [NSLOT:0] dir_q;
  logic          wb_q;
  logic          err_q;
  logic [31:0]   ctrl_q;
  logic [31:0]   stat_q;
  logic [15:0]   len_q;
  logic          jump_q;
  logic [6:0]    ext_q;
  logic [35:0]   ptr_q;

  logic          last_slot;
  logic [15:0]   rd_len;
  logic          unused_rsvd;

  assign last_slot   = (idx_q == SW'(NSLOT));
  assign rd_len      = mem_rdata[63:48];
  assign unused_rsvd = ^mem_rdata[39:36];

  assign busy      = (st_q != S_IDLE);
  assign err       = err_q;
  assign mem_req   = (st_q == S_READ) || (st_q == S_WBACK);
  assign mem_we    = (st_q == S_WBACK);
  assign mem_addr  = (st_q == S_WBACK) ? base_q : base_q + AW'({idx_q, 3'b000});
  assign mem_wdata = {ctrl_q, stat_q};

  assign prq_valid = (st_q == S_SEND);
  assign prq_slot  = idx_q;
  assign prq_addr  = AW'(ptr_q);
  assign prq_len   = len_q;
  assign prq_ext   = ext_q;
  assign prq_jump  = jump_q;
  assign prq_write = dir_q[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      base_q <= '0;
      dir_q  <= '0;
      wb_q   <= 1'b0;
      err_q  <= 1'b0;
      ctrl_q <= '0;
      stat_q <= '0;
      len_q  <= '0;
      jump_q <= 1'b0;
      ext_q  <= '0;
      ptr_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (db_valid) begin
          base_q <= db_addr;
          idx_q  <= '0;
          dir_q  <= {cfg_out_mask, 1'b0};
          wb_q   <= cfg_wb_en;
          err_q  <= 1'b0;
          st_q   <= S_READ;
        end
        S_READ: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            st_q  <= S_IDLE;
          end else if (idx_q == '0) begin
            ctrl_q <= mem_rdata[63:32];
            idx_q  <= SW'(1);
          end else if (rd_len == '0) begin
            if (last_slot) st_q <= S_WAIT;
            else           idx_q <= idx_q + SW'(1);
          end else begin
            len_q  <= rd_len;
            jump_q <= mem_rdata[47];
            ext_q  <= mem_rdata[46:40];
            ptr_q  <= mem_rdata[35:0];
            st_q   <= S_SEND;
          end
        end
        S_SEND: if (prq_ready) begin
          if (last_slot) st_q <= S_WAIT;
          else begin
            idx_q <= idx_q + SW'(1);
            st_q  <= S_READ;
          end
        end
        S_WAIT: if (job_done) begin
          stat_q <= job_status;
          st_q   <= wb_q ? S_WBACK : S_IDLE;
        end
        S_WBACK: if (mem_ack) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/desc_fetch_dispatch_chk.sv
module desc_fetch_dispatch_chk #(
  parameter int AW = 36,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          err,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          prq_valid,
  input logic          prq_ready,
  input logic [SW-1:0] prq_slot,
  input logic [AW-1:0] prq_addr,
  input logic [15:0]   prq_len,
  input logic [6:0]    prq_ext,
  input logic          prq_jump,
  input logic          prq_write
);

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    prq_valid && !prq_ready |=> prq_valid &&
      $stable({prq_slot, prq_addr, prq_len, prq_ext, prq_jump, prq_write}));

  a_r2_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r4_live_slot: assert property (@(posedge clk) disable iff (!rst_n)
    prq_valid |-> (prq_len != 16'd0) && (prq_slot != '0));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !prq_valid);

  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  a_r7_wb_alone: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !prq_valid);

endmodule

bind desc_fetch_dispatch desc_fetch_dispatch_chk #(.AW(AW), .SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .prq_valid(prq_valid), .prq_ready(prq_ready), .prq_slot(prq_slot),
  .prq_addr(prq_addr), .prq_len(prq_len), .prq_ext(prq_ext),
  .prq_jump(prq_jump), .prq_write(prq_write)
);

// File: tb/desc_fetch_dispatch_tb.sv
module desc_fetch_dispatch_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic        db_valid;
  logic [35:0] db_addr;
  logic [6:0]  cfg_out_mask;
  logic        cfg_wb_en;
  logic        busy, err;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [35:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic        prq_valid, prq_ready;
  logic [2:0]  prq_slot;
  logic [35:0] prq_addr;
  logic [15:0] prq_len;
  logic [6:0]  prq_ext;
  logic        prq_jump, prq_write;
  logic        job_done;
  logic [31:0] job_status;

  desc_fetch_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_addr(db_addr),
    .cfg_out_mask(cfg_out_mask), .cfg_wb_en(cfg_wb_en), .busy(busy), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .prq_valid(prq_valid), .prq_ready(prq_ready), .prq_slot(prq_slot),
    .prq_addr(prq_addr), .prq_len(prq_len), .prq_ext(prq_ext),
    .prq_jump(prq_jump), .prq_write(prq_write),
    .job_done(job_done), .job_status(job_status)
  );

  int total = 0;
  int fails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model
  logic [63:0] dmem [8];
  logic [35:0] base_t;
  int          n_reads, err_word, wb_cnt;
  logic        read_bad;
  logic [35:0] wb_addr;
  logic [63:0] wb_data;

  initial begin
    mem_ack = 0; mem_err = 0; mem_rdata = '0;
    n_reads = 0; err_word = 8; wb_cnt = 0; read_bad = 0;
    wb_addr = '0; wb_data = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 0; mem_err = 0;
      end else if (mem_req) begin
        if (mem_we) begin
          wb_cnt++; wb_addr = mem_addr; wb_data = mem_wdata;
        end else begin
          if (n_reads >= 8 || mem_addr !== base_t + 36'(8 * n_reads)) read_bad = 1;
          mem_rdata = dmem[n_reads[2:0]];
          mem_err   = (n_reads == err_word);
          n_reads++;
        end
        mem_ack = 1;
      end
    end
  end

  // downstream model
  logic [63:0] rq_log [8];
  int          n_req;
  logic        stall_mode;
  int          rcnt;

  initial begin
    prq_ready = 0; n_req = 0; stall_mode = 0; rcnt = 0;
    forever begin
      @(negedge clk);
      rcnt++;
      prq_ready = stall_mode ? (rcnt % 3 == 0) : 1'b1;
      if (prq_valid && prq_ready) begin
        if (n_req < 8) rq_log[n_req] = {prq_slot, prq_addr, prq_len, prq_ext, prq_jump, prq_write};
        n_req++;
      end
    end
  end

  // vectors: {len mask, jump mask, out mask, wb, status}; bit k-1 = slot k
  localparam int NV = 6;
  localparam logic [53:0] VEC [NV] = '{
    {7'b1111111, 7'b0000000, 7'b0000000, 1'b1, 32'h0000_0001},
    {7'b0000000, 7'b0000000, 7'b1111111, 1'b1, 32'h0000_0002},
    {7'b1010101, 7'b0010100, 7'b1110000, 1'b0, 32'h0000_0003},
    {7'b1000001, 7'b1000001, 7'b1000000, 1'b1, 32'hA5A5_5A5A},
    {7'b0111110, 7'b0101010, 7'b0011100, 1'b0, 32'h0000_0044},
    {7'b0000001, 7'b0000000, 7'b0000001, 1'b1, 32'hDEAD_BEEF}
  };

  task automatic run_job(input int v, input logic [6:0] lm, input logic [6:0] jm,
                         input logic [6:0] om, input logic wb, input logic [31:0] status,
                         input logic stall, input logic dup_db, input int errw);
    logic [63:0] exp_q [8];
    int          n_exp = 0;
    int          lim = (errw < 8) ? errw : 8;
    logic [31:0] ctrl = 32'hC0DE_0000 | 32'(v);
    base_t = 36'h8_0000_1000 + 36'(v * 'h100);
    dmem[0] = {ctrl, 32'hFFFF_FFFF};
    for (int k = 1; k < 8; k++) begin
      logic [15:0] len = lm[k-1] ? 16'h0040 + 16'(k * 'h11) : 16'h0;
      logic [31:0] pa  = 32'hA000_0000 + 32'(k * 256 + v);
      dmem[k] = {len, jm[k-1], 7'(k + v), 4'hF, 4'(k), pa};
      if (len != 0 && k < lim) begin
        exp_q[n_exp] = {3'(k), 4'(k), pa, len, 7'(k + v), jm[k-1], om[k-1]};
        n_exp++;
      end
    end
    n_reads = 0; n_req = 0; wb_cnt = 0; read_bad = 0; err_word = errw; stall_mode = stall;
    @(negedge clk);
    cfg_out_mask = om; cfg_wb_en = wb; db_addr = base_t; db_valid = 1;
    @(negedge clk);
    db_valid = 0; cfg_out_mask = ~om; cfg_wb_en = ~wb;
    chk($sformatf("R8 busy after doorbell job %0d", v), 64'(busy), 64'd1);
    chk($sformatf("R9 err cleared on doorbell job %0d", v), 64'(err), 64'd0);
    if (dup_db) begin
      @(negedge clk); db_addr = 36'h0_DEAD_0000; db_valid = 1;
      @(negedge clk); db_valid = 0;
    end
    while (n_reads < 8 && busy) @(negedge clk);
    if (errw >= 8) begin
      repeat (20) @(negedge clk);
      job_status = status; job_done = 1;
      @(negedge clk);
      job_done = 0;
      for (int w = 0; w < 40 && busy; w++) @(negedge clk);
    end else begin
      repeat (6) @(negedge clk);
    end
    chk($sformatf("R2 read sequence job %0d", v), {read_bad, 63'(n_reads)},
        {1'b0, 63'((errw < 8) ? errw + 1 : 8)});
    chk($sformatf("R4 request count job %0d", v), 64'(n_req), 64'(n_exp));
    for (int i = 0; i < n_exp && i < n_req; i++)
      chk($sformatf("R3 R5 request %0d job %0d", i, v), rq_log[i], exp_q[i]);
    chk($sformatf("R7 writeback count job %0d", v), 64'(wb_cnt), 64'((wb && errw >= 8) ? 1 : 0));
    if (wb && errw >= 8) begin
      chk($sformatf("R7 writeback addr job %0d", v), 64'(wb_addr), 64'(base_t));
      chk($sformatf("R7 writeback data job %0d", v), wb_data, {ctrl, status});
    end
    chk($sformatf("R8 idle at end job %0d", v), 64'(busy), 64'd0);
    chk($sformatf("R9 err flag job %0d", v), 64'(err), 64'((errw < 8) ? 1 : 0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 0; db_valid = 0; db_addr = '0; cfg_out_mask = '0; cfg_wb_en = 0;
    job_done = 0; job_status = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {60'd0, busy, err, mem_req, prq_valid}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {60'd0, busy, err, mem_req, prq_valid}, 64'd0);

    for (int i = 0; i < NV; i++)
      run_job(i, VEC[i][53:47], VEC[i][46:40], VEC[i][39:33], VEC[i][32], VEC[i][31:0],
              1'b0, 1'b0, 8);

    run_job(6, 7'b1111111, 7'b0110011, 7'b1010101, 1'b1, 32'h0000_0077, 1'b1, 1'b0, 8); // R6
    run_job(7, 7'b1111111, 7'b0000000, 7'b0000000, 1'b1, 32'h0000_0088, 1'b0, 1'b1, 8); // R8
    run_job(8, 7'b1111111, 7'b0000100, 7'b0000011, 1'b1, 32'h0000_0099, 1'b0, 1'b0, 3); // R9
    run_job(9, 7'b0000011, 7'b0000010, 7'b0000001, 1'b1, 32'h0000_00AA, 1'b0, 1'b0, 8); // R9 clear
    run_job(10, 7'b1111111, 7'b0000000, 7'b0000000, 1'b0, 32'h0, 1'b0, 1'b0, 0);        // R9 header error

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule